// File: doc/BRIEF.md
# Teletext Packet Store Address Mapper

This block turns each received Teletext packet byte into a byte address in external page memory. Every page store is 1 KB. A store number picks the 1 KB region and a quadrant field sits above it. Display rows 0 to 25 go into the store that the active acquisition circuit has selected. Two fixed stores hold the extra data. Store 0 serves acquisition circuit A and store 1 serves circuit B. In those stores, auxiliary packets X/26, X/27 and X/28 are packed one after another into 40-byte slots in the order they arrive. Packet 8/29 and packet 8/30 have fixed areas of their own, and packet X/31 has a short area in store 0.

Each byte arrives with its packet identity, its byte index and a flag that marks the first byte of the packet. One cycle later the block reports the address together with a write strobe or a drop strobe. Bytes are dropped when a write-inhibit flag is set, when the index is out of range, when the magazine does not fit the packet number, or when the auxiliary slot area is full. For 8/30 packets, the store is chosen from the designation code.

Top module: `pkt_store_mapper`

## Requirements
- R1: After synchronous reset, out_valid, out_we and out_drop are all low and out_addr is zero.
- R2: A packet numbered 0 to 24 from circuit A (in_acq_b=0) writes to {in_quad, in_store_a, pkt*40+idx}. From circuit B it uses in_store_b instead.
- R3: Packet 25 writes offset 1000+idx for idx 0 to 23 and drops idx 24 and higher, so the store never exceeds 1024 bytes.
- R4: A byte index above 39 is dropped for every packet number.
- R5: X/26, X/27 and X/28 packets write offset 0x18 + slot*40 + idx. The store is store 0 for circuit A and store 1 for circuit B. The slot number is taken on the first byte (in_first=1) and counts up in arrival order from 0.
- R6: Each circuit accepts at most 23 auxiliary packets. Every byte of a 24th or later packet is dropped.
- R7: The first byte of a packet 0 resets that circuit's auxiliary count to zero, even when the packet-0 write is inhibited. The other circuit's count is left as it was.
- R8: Packet 29 from magazine 8 (in_mag code 0) writes offset 0x3B0+idx in the circuit's auxiliary store (0 for A, 1 for B). Packet 29 from any other magazine is dropped.
- R9: Packet 30 from magazine 8 writes offset 0x3D8+idx. Designation codes 0,1,4,5,8,9,C,D select store 0 and codes 2,3,6,7,A,B,E,F select store 1. Packet 30 from any other magazine is dropped.
- R10: Packet 31 writes store 0 at offset 0x10+idx for idx 0 to 7 and drops higher indices.
- R11: When inh_p0, inh_p24, inh_p25 or inh_p29 is high, packets 0, 24, 25 or 8/29 respectively are dropped.
- R12: Each input byte gives exactly one output cycle, one clock later. That cycle has out_we high if the byte is written, or out_drop high if it is dropped, never both. A cycle with no input byte gives neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A packet byte is presented |
| in_first | input | 1 | Byte is the first of its packet |
| in_acq_b | input | 1 | Packet belongs to acquisition circuit B |
| in_mag | input | 3 | Magazine code (0 means magazine 8) |
| in_pkt | input | 5 | Packet number 0 to 31 |
| in_dc | input | 4 | Designation code of an 8/30 packet |
| in_idx | input | 6 | Byte index within the packet |
| in_quad | input | 2 | Memory quadrant, address bits 17:16 |
| in_store_a | input | 6 | Page store chosen for circuit A |
| in_store_b | input | 6 | Page store chosen for circuit B |
| inh_p0 | input | 1 | Inhibit writes of packet 0 |
| inh_p24 | input | 1 | Inhibit writes of packet 24 |
| inh_p25 | input | 1 | Inhibit writes of packet 25 |
| inh_p29 | input | 1 | Inhibit writes of packet 8/29 |
| out_valid | output | 1 | Result for the byte of the previous cycle |
| out_we | output | 1 | Byte is to be written at out_addr |
| out_drop | output | 1 | Byte is discarded |
| out_addr | output | 18 | Memory byte address |

## Verification
Directed sequences cover each packet class at its edge indices. They cover all sixteen 8/30 designation codes, which separates the two routing groups, and a run of 24 auxiliary packets, which shows the cut between slot 22 and the dropped 24th. Headers are sent on one circuit while the other is partly filled, inhibited and not inhibited, to show that the count resets per circuit. Random packets with mixed circuits, magazines, quadrants, stores and inhibit flags then run against a bench model. They catch wrong store choices, wrong slot order and wrong drops under interleaving that the directed cases do not reach.

// File: rtl/pkt_map_pkg.sv
package pkt_map_pkg;

    localparam int OFS_W      = 10;
    localparam int IDX_W      = 6;
    localparam int ROW_BYTES  = 40;
    localparam int ROW25_LAST = 23;
    localparam int X31_LAST   = 7;
    localparam logic [OFS_W-1:0] AUX_BASE = 10'h018;
    localparam logic [OFS_W-1:0] P29_BASE = 10'h3B0;
    localparam logic [OFS_W-1:0] P30_BASE = 10'h3D8;
    localparam logic [OFS_W-1:0] X31_BASE = 10'h010;
    localparam logic [2:0] MAG8_CODE = 3'd0;

    typedef enum logic [2:0] {
        PK_ROW,
        PK_AUX,
        PK_P29,
        PK_P30,
        PK_X31,
        PK_NONE
    } pkt_kind_e;

    typedef struct packed {
        pkt_kind_e kind;
        logic      drop;
    } pkt_class_t;

    function automatic logic [OFS_W-1:0] row_offset(input logic [4:0] pkt,
                                                   input logic [IDX_W-1:0] idx);
        return OFS_W'(pkt) * OFS_W'(ROW_BYTES) + OFS_W'(idx);
    endfunction

    function automatic logic [OFS_W-1:0] slot_offset(input logic [OFS_W-1:0] slot,
                                                    input logic [IDX_W-1:0] idx);
        return AUX_BASE + slot * OFS_W'(ROW_BYTES) + OFS_W'(idx);
    endfunction

    // Codes whose bit 1 is set go to the second auxiliary store
    function automatic logic p30_to_store1(input logic [3:0] dc);
        return dc inside {4'h2, 4'h3, 4'h6, 4'h7, 4'hA, 4'hB, 4'hE, 4'hF};
    endfunction

endpackage

// File: rtl/pkt_classify.sv
module pkt_classify
    import pkt_map_pkg::*;
(
    input  logic [2:0]       mag,
    input  logic [4:0]       pkt,
    input  logic [IDX_W-1:0] idx,
    input  logic             inh_p0,
    input  logic             inh_p24,
    input  logic             inh_p25,
    input  logic             inh_p29,
    output pkt_class_t       cls
);
    logic is_m8;
    logic idx_over;

    always_comb begin
        is_m8    = (mag == MAG8_CODE);
        idx_over = (idx > IDX_W'(ROW_BYTES - 1));

        if (pkt <= 5'd25)
            cls.kind = PK_ROW;
        else if (pkt <= 5'd28)
            cls.kind = PK_AUX;
        else if (pkt == 5'd29)
            cls.kind = is_m8 ? PK_P29 : PK_NONE;
        else if (pkt == 5'd30)
            cls.kind = is_m8 ? PK_P30 : PK_NONE;
        else
            cls.kind = PK_X31;

        cls.drop = idx_over || (cls.kind == PK_NONE);
        if (pkt == 5'd0  && inh_p0)  cls.drop = 1'b1;
        if (pkt == 5'd24 && inh_p24) cls.drop = 1'b1;
        if (pkt == 5'd25 && (inh_p25 || idx > IDX_W'(ROW25_LAST))) cls.drop = 1'b1;
        if (cls.kind == PK_P29 && inh_p29) cls.drop = 1'b1;
        if (cls.kind == PK_X31 && idx > IDX_W'(X31_LAST)) cls.drop = 1'b1;
    end
endmodule

// File: rtl/aux_slot_track.sv
module aux_slot_track #(
    parameter int SLOTS  = 23,
    parameter int CNT_W  = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_start,
    input  logic             ev_header,
    input  logic             ev_aux,
    output logic [CNT_W-1:0] slot_now,
    output logic             full_now
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] slot_q;
    logic             full_q;
    logic             at_limit;

    assign at_limit = (cnt_q == CNT_W'(SLOTS));
    assign slot_now = ev_start ? cnt_q : slot_q;
    assign full_now = ev_start ? at_limit : full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            slot_q <= '0;
            full_q <= 1'b0;
        end else if (ev_start) begin
            if (ev_header) begin
                cnt_q <= '0;
            end else if (ev_aux) begin
                if (at_limit) begin
                    full_q <= 1'b1;
                end else begin
                    slot_q <= cnt_q;
                    full_q <= 1'b0;
                    cnt_q  <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/store_addr_gen.sv
module store_addr_gen
    import pkt_map_pkg::*;
#(
    parameter int QUAD_W  = 2,
    parameter int STORE_W = 6,
    parameter int SLOT_W  = 5,
    localparam int ADDR_W = QUAD_W + STORE_W + OFS_W
) (
    input  pkt_kind_e           kind,
    input  logic                acq_b,
    input  logic [3:0]          dc,
    input  logic [QUAD_W-1:0]   quad,
    input  logic [STORE_W-1:0]  store_a,
    input  logic [STORE_W-1:0]  store_b,
    input  logic [4:0]          pkt,
    input  logic [IDX_W-1:0]    idx,
    input  logic [SLOT_W-1:0]   slot,
    output logic [ADDR_W-1:0]   addr
);
    logic [STORE_W-1:0] st;
    logic [OFS_W-1:0]   ofs;

    always_comb begin
        st  = '0;
        ofs = '0;
        unique case (kind)
            PK_ROW: begin
                st  = acq_b ? store_b : store_a;
                ofs = row_offset(pkt, idx);
            end
            PK_AUX: begin
                st  = STORE_W'(acq_b);
                ofs = slot_offset(OFS_W'(slot), idx);
            end
            PK_P29: begin
                st  = STORE_W'(acq_b);
                ofs = P29_BASE + OFS_W'(idx);
            end
            PK_P30: begin
                st  = STORE_W'(p30_to_store1(dc));
                ofs = P30_BASE + OFS_W'(idx);
            end
            PK_X31: begin
                st  = '0;
                ofs = X31_BASE + OFS_W'(idx);
            end
            default: begin
                st  = '0;
                ofs = '0;
            end
        endcase
        addr = {quad, st, ofs};
    end
endmodule

// File: rtl/pkt_store_mapper.sv
module pkt_store_mapper
    import pkt_map_pkg::*;
#(
    parameter int QUAD_W    = 2,
    parameter int STORE_W   = 6,
    parameter int AUX_SLOTS = 23,
    localparam int ADDR_W   = QUAD_W + STORE_W + OFS_W,
    localparam int SLOT_W   = $clog2(AUX_SLOTS + 1),
    localparam int N_ACQ    = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_first,
    input  logic               in_acq_b,
    input  logic [2:0]         in_mag,
    input  logic [4:0]         in_pkt,
    input  logic [3:0]         in_dc,
    input  logic [5:0]         in_idx,
    input  logic [QUAD_W-1:0]  in_quad,
    input  logic [STORE_W-1:0] in_store_a,
    input  logic [STORE_W-1:0] in_store_b,
    input  logic               inh_p0,
    input  logic               inh_p24,
    input  logic               inh_p25,
    input  logic               inh_p29,
    output logic               out_valid,
    output logic               out_we,
    output logic               out_drop,
    output logic [ADDR_W-1:0]  out_addr
);
    pkt_class_t        cls;
    logic [SLOT_W-1:0] slot_now [N_ACQ];
    logic              full_now [N_ACQ];
    logic [SLOT_W-1:0] slot_sel;
    logic              full_sel;
    logic              drop_now;
    logic [ADDR_W-1:0] addr_now;

    pkt_classify u_cls (
        .mag     (in_mag),
        .pkt     (in_pkt),
        .idx     (in_idx),
        .inh_p0  (inh_p0),
        .inh_p24 (inh_p24),
        .inh_p25 (inh_p25),
        .inh_p29 (inh_p29),
        .cls     (cls)
    );

    for (genvar g = 0; g < N_ACQ; g++) begin : g_acq
        logic mine;
        assign mine = in_valid && in_first && (in_acq_b == 1'(g));
        aux_slot_track #(
            .SLOTS (AUX_SLOTS),
            .CNT_W (SLOT_W)
        ) u_trk (
            .clk       (clk),
            .rst       (rst),
            .ev_start  (mine),
            .ev_header (in_pkt == 5'd0),
            .ev_aux    (cls.kind == PK_AUX),
            .slot_now  (slot_now[g]),
            .full_now  (full_now[g])
        );
    end

    assign slot_sel = in_acq_b ? slot_now[1] : slot_now[0];
    assign full_sel = in_acq_b ? full_now[1] : full_now[0];
    assign drop_now = cls.drop || ((cls.kind == PK_AUX) && full_sel);

    store_addr_gen #(
        .QUAD_W  (QUAD_W),
        .STORE_W (STORE_W),
        .SLOT_W  (SLOT_W)
    ) u_gen (
        .kind    (cls.kind),
        .acq_b   (in_acq_b),
        .dc      (in_dc),
        .quad    (in_quad),
        .store_a (in_store_a),
        .store_b (in_store_b),
        .pkt     (in_pkt),
        .idx     (in_idx),
        .slot    (slot_sel),
        .addr    (addr_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_we    <= 1'b0;
            out_drop  <= 1'b0;
            out_addr  <= '0;
        end else begin
            out_valid <= in_valid;
            out_we    <= in_valid && !drop_now;
            out_drop  <= in_valid && drop_now;
            out_addr  <= (in_valid && !drop_now) ? addr_now : '0;
        end
    end
endmodule

// File: rtl/pkt_store_mapper_chk.sv
module pkt_store_mapper_chk #(
    parameter int QUAD_W  = 2,
    parameter int STORE_W = 6,
    localparam int OFS_W  = 10,
    localparam int ADDR_W = QUAD_W + STORE_W + OFS_W
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [2:0]         in_mag,
    input logic [4:0]         in_pkt,
    input logic [3:0]         in_dc,
    input logic [5:0]         in_idx,
    input logic [QUAD_W-1:0]  in_quad,
    input logic               inh_p0,
    input logic               out_valid,
    input logic               out_we,
    input logic               out_drop,
    input logic [ADDR_W-1:0]  out_addr
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_we && !out_drop)); // R12

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_valid && (out_we != out_drop))); // R12

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_idx > 6'd39) |=> out_drop); // R4

    AST_ROW25_TAIL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_pkt == 5'd25 && in_idx > 6'd23) |=> out_drop); // R3

    AST_HDR_INHIBIT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_pkt == 5'd0 && inh_p0) |=> out_drop); // R11

    AST_X29_MAG: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mag != 3'd0 && in_pkt == 5'd29) |=> out_drop); // R8

    AST_X31_MAP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_pkt == 5'd31 && in_idx < 6'd8) |=>
        (out_we && out_addr == {$past(in_quad), {STORE_W{1'b0}},
                                10'h010 + 10'($past(in_idx))})); // R10

    AST_P30_ROUTE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mag == 3'd0 && in_pkt == 5'd30 && in_idx < 6'd40) |=>
        (out_we && out_addr[OFS_W+STORE_W-1:OFS_W] == STORE_W'($past(in_dc[1])))); // R9
endmodule

bind pkt_store_mapper pkt_store_mapper_chk #(
    .QUAD_W  (QUAD_W),
    .STORE_W (STORE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_mag    (in_mag),
    .in_pkt    (in_pkt),
    .in_dc     (in_dc),
    .in_idx    (in_idx),
    .in_quad   (in_quad),
    .inh_p0    (inh_p0),
    .out_valid (out_valid),
    .out_we    (out_we),
    .out_drop  (out_drop),
    .out_addr  (out_addr)
);

// File: tb/pkt_store_mapper_bench.sv
module pkt_store_mapper_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_first, in_acq_b;
    logic [2:0]  in_mag;
    logic [4:0]  in_pkt;
    logic [3:0]  in_dc;
    logic [5:0]  in_idx;
    logic [1:0]  in_quad;
    logic [5:0]  in_store_a, in_store_b;
    logic        inh_p0, inh_p24, inh_p25, inh_p29;
    logic        out_valid, out_we, out_drop;
    logic [17:0] out_addr;

    int n_run  = 0;
    int n_fail = 0;
    int m_cnt  [2];
    int m_slot [2];
    bit m_full [2];
    bit done = 1'b0;

    always #4 clk = ~clk;

    pkt_store_mapper u_pkt_store_mapper (.*);

    task automatic check(input string req, input bit ok, input string got, input string exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %s expected %s", req, got, exp);
        end
    endtask

    task automatic model(input bit first, input bit acq, input logic [2:0] mag,
                         input logic [4:0] pkt, input logic [3:0] dc, input logic [5:0] idx,
                         output bit drop, output int addr, output string req);
        int a = acq ? 1 : 0;
        int st = 0, ofs = 0;
        bit m8 = (mag == 3'd0);
        drop = (idx > 39);
        req = "R2";
        if (first && pkt == 0) m_cnt[a] = 0;
        if (pkt <= 25) begin
            st = acq ? int'(in_store_b) : int'(in_store_a);
            ofs = pkt * 40 + idx;
            if (pkt == 25) begin req = "R3"; if (idx > 23) drop = 1; end
            if ((pkt == 0 && inh_p0) || (pkt == 24 && inh_p24) || (pkt == 25 && inh_p25)) begin
                drop = 1; req = "R11";
            end
        end else if (pkt <= 28) begin
            if (first) begin
                if (m_cnt[a] < 23) begin m_slot[a] = m_cnt[a]; m_full[a] = 0; m_cnt[a]++; end
                else m_full[a] = 1;
            end
            st = a; ofs = 24 + m_slot[a] * 40 + idx;
            req = "R5";
            if (m_full[a]) begin drop = 1; req = "R6"; end
        end else if (pkt == 29) begin
            st = a; ofs = 'h3B0 + idx; req = "R8";
            if (!m8) drop = 1;
            if (m8 && inh_p29) begin drop = 1; req = "R11"; end
        end else if (pkt == 30) begin
            st = dc[1]; ofs = 'h3D8 + idx; req = "R9";
            if (!m8) drop = 1;
        end else begin
            st = 0; ofs = 'h10 + idx; req = "R10";
            if (idx > 7) drop = 1;
        end
        if (idx > 39) req = "R4";
        addr = (int'(in_quad) << 16) | (st << 10) | ofs;
    endtask

    task automatic send(input bit first, input bit acq, input logic [2:0] mag,
                        input logic [4:0] pkt, input logic [3:0] dc, input logic [5:0] idx);
        bit    e_drop;
        int    e_addr;
        string req;
        @(negedge clk);
        in_valid = 1; in_first = first; in_acq_b = acq; in_mag = mag;
        in_pkt = pkt; in_dc = dc; in_idx = idx;
        model(first, acq, mag, pkt, dc, idx, e_drop, e_addr, req);
        @(posedge clk);
        #1;
        check(req, out_valid && out_drop == e_drop && out_we == !e_drop &&
                   (e_drop || int'(out_addr) == e_addr),
              $sformatf("v=%0b we=%0b drop=%0b addr=%05h", out_valid, out_we, out_drop, out_addr),
              $sformatf("v=1 we=%0b drop=%0b addr=%05h", !e_drop, e_drop, e_addr));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 0; in_first = 0;
        @(posedge clk);
        #1;
        check("R12", !out_valid && !out_we && !out_drop,
              $sformatf("v=%0b we=%0b drop=%0b", out_valid, out_we, out_drop), "v=0 we=0 drop=0");
    endtask

    task automatic aux_pkt(input bit acq, input logic [4:0] pkt);
        send(1, acq, 3'd4, pkt, 4'd0, 6'd0);
        send(0, acq, 3'd4, pkt, 4'd0, 6'd39);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1));
        rst = 1; in_valid = 0; in_first = 0; in_acq_b = 0; in_mag = 0; in_pkt = 0;
        in_dc = 0; in_idx = 0; in_quad = 2'd1; in_store_a = 6'd5; in_store_b = 6'd9;
        inh_p0 = 0; inh_p24 = 0; inh_p25 = 0; inh_p29 = 0;
        for (int i = 0; i < 2; i++) begin m_cnt[i] = 0; m_slot[i] = 0; m_full[i] = 0; end
        repeat (3) @(posedge clk);
        #1;
        check("R1", !out_valid && !out_we && !out_drop && out_addr == 0,
              $sformatf("v=%0b we=%0b drop=%0b addr=%05h", out_valid, out_we, out_drop, out_addr),
              "all zero");
        @(negedge clk); rst = 0;

        // R2 rows on both circuits
        for (int i = 0; i < 40; i++) send(i == 0, 0, 3'd2, 5'd3, 4'd0, 6'(i));
        send(1, 1, 3'd2, 5'd24, 4'd0, 6'd0);
        send(0, 1, 3'd2, 5'd24, 4'd0, 6'd39);
        // R3 row 25 edge, R4 index overflow
        send(1, 0, 3'd2, 5'd25, 4'd0, 6'd22);
        send(0, 0, 3'd2, 5'd25, 4'd0, 6'd23);
        send(0, 0, 3'd2, 5'd25, 4'd0, 6'd24);
        send(1, 0, 3'd2, 5'd7, 4'd0, 6'd40);
        send(0, 0, 3'd2, 5'd7, 4'd0, 6'd63);
        idle();

        // R5 R6: fill circuit A, partial circuit B
        send(1, 0, 3'd4, 5'd0, 4'd0, 6'd0);
        for (int k = 0; k < 25; k++) aux_pkt(0, 5'(26 + k % 3));
        send(1, 1, 3'd4, 5'd0, 4'd0, 6'd0);
        aux_pkt(1, 5'd27);
        aux_pkt(1, 5'd26);
        // R7: inhibited header on A resets A only
        inh_p0 = 1;
        send(1, 0, 3'd4, 5'd0, 4'd0, 6'd0);
        inh_p0 = 0;
        aux_pkt(0, 5'd28);
        aux_pkt(1, 5'd28);

        // R8 packet 29
        send(1, 0, 3'd0, 5'd29, 4'd0, 6'd0);
        send(1, 1, 3'd0, 5'd29, 4'd0, 6'd39);
        send(1, 0, 3'd3, 5'd29, 4'd0, 6'd5);
        inh_p29 = 1;
        send(1, 0, 3'd0, 5'd29, 4'd0, 6'd5);
        inh_p29 = 0;
        // R9 every designation code
        for (int c = 0; c < 16; c++) begin
            send(1, 0, 3'd0, 5'd30, 4'(c), 6'd0);
            send(0, 0, 3'd0, 5'd30, 4'(c), 6'd39);
        end
        send(1, 0, 3'd2, 5'd30, 4'd1, 6'd0);
        // R10 packet 31
        send(1, 1, 3'd5, 5'd31, 4'd0, 6'd0);
        send(0, 1, 3'd5, 5'd31, 4'd0, 6'd7);
        send(0, 1, 3'd5, 5'd31, 4'd0, 6'd8);
        // R11 row inhibits
        inh_p24 = 1; inh_p25 = 1;
        send(1, 0, 3'd1, 5'd24, 4'd0, 6'd1);
        send(1, 0, 3'd1, 5'd25, 4'd0, 6'd1);
        inh_p24 = 0; inh_p25 = 0;
        idle();

        // Random packets
        for (int p = 0; p < 400; p++) begin
            bit         acq = 1'($urandom);
            logic [2:0] mag = ($urandom % 3 == 0) ? 3'd0 : 3'($urandom);
            logic [4:0] pkt;
            logic [3:0] dc = 4'($urandom);
            int         len = 1 + $urandom % 6;
            int         idx = ($urandom % 8 == 0) ? 30 + $urandom % 20 : $urandom % 40;
            case ($urandom % 4)
                0: pkt = 5'(26 + $urandom % 3);
                1: pkt = ($urandom % 3 == 0) ? 5'd0 : 5'(24 + $urandom % 2);
                default: pkt = 5'($urandom);
            endcase
            in_quad = 2'($urandom); in_store_a = 6'($urandom); in_store_b = 6'($urandom);
            inh_p0 = ($urandom % 5 == 0); inh_p24 = ($urandom % 5 == 0);
            inh_p25 = ($urandom % 5 == 0); inh_p29 = ($urandom % 5 == 0);
            for (int b = 0; b < len; b++) send(b == 0, acq, mag, pkt, dc, 6'((idx + b) % 64));
            if ($urandom % 6 == 0) idle();
        end
        idle();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule